// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block turns a parallel character into an asynchronous serial frame on a single output line. A byte written with a one-cycle strobe goes into a one-character holding register. As soon as the shifter is free and transmission is enabled, the byte moves into the shifter. The shifter then sends a low start bit, the data bits least significant first, an optional parity bit and a stop period. Mode inputs select:

- the character length (5 to 8 bits);
- whether parity is used, and its sense;
- the stop length (1, 1.5 or 2 bits);
- the clock-per-bit factor (1, 16 or 64).

Length, parity, factor and stop length are captured when each character enters the shifter.

The whole block runs on the falling edge of the transmit clock. A ready flag tells the producer when the holding register can take another byte. A separate break input forces the line low for as long as it is held. The break does not disturb the frame sequencing underneath.

Top module: `async_tx_break`

## Requirements
- R1: After reset the line is high, and it stays high whenever no frame is in progress and break is off. The ready output equals transmit enable AND holding register empty.
- R2: A frame consists of one low start bit, then the data bits least significant bit first, then the parity bit when enabled, then a high stop period.
- R3: len_sel selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only the low-order bits of that length are sent, and the upper bits of the written byte have no effect on the line.
- R4: With par_en=1, a parity bit follows the data bits and is not counted in the character length. par_odd=1 makes the count of ones in data plus parity odd, and par_odd=0 makes it even. With par_en=0 no parity bit is sent.
- R5: rate_sel sets the length of every bit: 00 gives 1 clock, 01 gives 16 clocks, and 10 or 11 give 64 clocks.
- R6: stop_sel sets the stop period. 00 and 01 give one bit period and 11 gives two. 10 gives one and a half bit periods, or two clocks when rate_sel is 00.
- R7: When the block is idle and enabled, a byte captured at one falling edge starts its start bit at the next falling edge.
- R8: Any write makes ready low at the following edge. A byte written while the shifter is busy waits in the holding register. Its start bit follows the last stop clock of the current frame with no idle gap.
- R9: While tx_en is low no new frame starts and ready is low. A frame already in progress still completes.
- R10: One falling edge after brk rises the line goes low, and it stays low until one edge after brk falls. Frames keep advancing underneath, so the holding register still empties during a break.
- R11: The line changes only on falling edges of the transmit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Character to send |
| wr_stb | input | 1 | One-cycle write strobe for wr_data |
| tx_en | input | 1 | Allows new frames to start |
| brk | input | 1 | Forces the line low while high |
| len_sel | input | 2 | Character length code |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity sense, 1 = odd |
| stop_sel | input | 2 | Stop length code |
| rate_sel | input | 2 | Clocks-per-bit code |
| txd | output | 1 | Serial output line |
| tx_rdy | output | 1 | Holding register can accept a byte |

## Verification
The bench compares every clock of each frame against a model, so each of these errors shows up:

- A frame that is a clock short or long, or a parity bit with the wrong sense.
- A 1.5-stop setting at factor 1 that rounds down to one clock and lets the next start bit begin early.
- A 5-bit character that leaks its upper bits into the parity.
- A queued byte that loses its place, or leaves an idle gap, when written the cycle after the previous byte loaded.
- A break that stalls the shifter and leaves ready stuck low afterwards.
- A disabled transmitter that still starts a frame.

// File: rtl/async_tx_break.sv
`timescale 1ns/1ps
module async_tx_break #(
  parameter int MID_DIV  = 16,
  parameter int HIGH_DIV = 64
) (
  input  logic       tx_clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  input  logic       tx_en,
  input  logic       brk,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] stop_sel,
  input  logic [1:0] rate_sel,
  output logic       txd,
  output logic       tx_rdy
);
  localparam int CW = $clog2(2*HIGH_DIV + 1);
  localparam int FW = 10;

  logic [7:0]    hold_q;
  logic          hold_full, busy, in_stop, line_q, brk_q;
  logic [FW-1:0] sh_q;
  logic [3:0]    left_q;
  logic [CW-1:0] cnt_q, per_q, stop_q;

  logic [3:0]    dlen;
  logic [7:0]    dval;
  logic          par_bit;
  logic [FW-1:0] nxt_sh;
  logic [CW-1:0] per_c, stop_c;
  logic          frame_done, start_now;

  assign dlen    = 4'd5 + {2'b00, len_sel};
  assign dval    = hold_q & (8'hFF >> (4'd8 - dlen));
  assign par_bit = (^dval) ^ par_odd;
  assign nxt_sh  = {2'b00, dval} | (FW'(par_en & par_bit) << dlen);

  always_comb begin
    case (rate_sel)
      2'b00:   per_c = CW'(1);
      2'b01:   per_c = CW'(MID_DIV);
      default: per_c = CW'(HIGH_DIV);
    endcase
    case (stop_sel)
      2'b11:   stop_c = per_c << 1;
      2'b10:   stop_c = (per_c == CW'(1)) ? CW'(2) : per_c + (per_c >> 1);
      default: stop_c = per_c;
    endcase
  end

  assign frame_done = busy && in_stop && (cnt_q == '0);
  assign start_now  = hold_full && tx_en && (!busy || frame_done);

  always_ff @(negedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      in_stop   <= 1'b0;
      line_q    <= 1'b1;
      brk_q     <= 1'b0;
      sh_q      <= '0;
      left_q    <= '0;
      cnt_q     <= '0;
      per_q     <= '0;
      stop_q    <= '0;
    end else begin
      brk_q <= brk;
      if (start_now) hold_full <= 1'b0;
      if (wr_stb) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
      if (start_now) begin
        busy    <= 1'b1;
        in_stop <= 1'b0;
        line_q  <= 1'b0;
        sh_q    <= nxt_sh;
        left_q  <= dlen + {3'b000, par_en};
        cnt_q   <= per_c - CW'(1);
        per_q   <= per_c - CW'(1);
        stop_q  <= stop_c - CW'(1);
      end else if (busy) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end else if (left_q != '0) begin
          line_q <= sh_q[0];
          sh_q   <= sh_q >> 1;
          left_q <= left_q - 4'd1;
          cnt_q  <= per_q;
        end else if (!in_stop) begin
          in_stop <= 1'b1;
          line_q  <= 1'b1;
          cnt_q   <= stop_q;
        end else begin
          busy    <= 1'b0;
          in_stop <= 1'b0;
        end
      end
    end
  end

  assign txd    = line_q & ~brk_q;
  assign tx_rdy = tx_en & ~hold_full;
endmodule

// File: rtl/async_tx_break_chk.sv
`timescale 1ns/1ps
module async_tx_break_chk (
  input logic tx_clk,
  input logic rst_n,
  input logic wr_stb,
  input logic tx_en,
  input logic brk,
  input logic txd,
  input logic tx_rdy,
  input logic busy,
  input logic in_stop,
  input logic brk_q,
  input logic hold_full
);
  AST_BREAK_HOLDS_LOW: assert property (@(negedge tx_clk) disable iff (!rst_n)
    brk |=> !txd); // R10
  AST_IDLE_MARKS: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (!busy && !brk_q) |-> txd); // R1
  AST_STOP_MARKS: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (in_stop && !brk_q) |-> txd); // R6
  AST_WRITE_CLEARS_READY: assert property (@(negedge tx_clk) disable iff (!rst_n)
    wr_stb |=> !tx_rdy); // R8
  AST_DISABLED_NO_START: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy); // R9
  AST_START_LOW: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (!busy && hold_full && tx_en && !brk) |=> (busy && !txd)); // R7
endmodule

bind async_tx_break async_tx_break_chk u_chk (
  .tx_clk(tx_clk), .rst_n(rst_n), .wr_stb(wr_stb), .tx_en(tx_en), .brk(brk),
  .txd(txd), .tx_rdy(tx_rdy), .busy(busy), .in_stop(in_stop), .brk_q(brk_q),
  .hold_full(hold_full)
);

// File: tb/tb_async_tx_break.sv
`timescale 1ns/1ps
module tb_async_tx_break;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_stb = 1'b0, tx_en = 1'b1, brk = 1'b0;
  logic [1:0] len_sel = '0, stop_sel = '0, rate_sel = '0;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       txd, tx_rdy;
  int total = 0, bad = 0;
  int m_len = 0, m_pe = 0, m_po = 0, m_rate = 0, m_stp = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  async_tx_break dut (
    .tx_clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_stb(wr_stb),
    .tx_en(tx_en), .brk(brk), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .stop_sel(stop_sel), .rate_sel(rate_sel),
    .txd(txd), .tx_rdy(tx_rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int per_of(input int r);
    return (r == 0) ? 1 : (r == 1) ? 16 : 64;
  endfunction

  function automatic int stop_of(input int s, input int r);
    int f = per_of(r);
    if (s == 3) return 2 * f;
    if (s == 2) return (f == 1) ? 2 : f + f / 2;
    return f;
  endfunction

  task automatic set_mode(input int l, input int pe, input int po, input int r, input int s);
    m_len = l; m_pe = pe; m_po = po; m_rate = r; m_stp = s;
    len_sel = 2'(l); par_en = pe[0]; par_odd = po[0];
    rate_sel = 2'(r); stop_sel = 2'(s);
  endtask

  task automatic check_frame(input logic [7:0] d);
    int f = per_of(m_rate);
    int n = 5 + m_len;
    int tot = f * (1 + n + m_pe) + stop_of(m_stp, m_rate);
    logic [7:0] m = d & 8'((1 << n) - 1);
    logic p = (^m) ^ m_po[0];
    for (int i = 0; i < tot; i++) begin
      int b = i / f;
      logic e;
      string tag;
      if (b == 0) begin e = 1'b0; tag = "R2 start"; end
      else if (b <= n) begin e = m[b-1]; tag = "R3 data R5"; end
      else if (m_pe != 0 && b == n + 1) begin e = p; tag = "R4 parity"; end
      else begin e = 1'b1; tag = "R6 stop"; end
      chk(txd === e, tag, int'(txd), int'(e));
      #3;
      chk(txd === e, "R11 mid-cycle", int'(txd), int'(e));
      step();
    end
  endtask

  task automatic send(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    step();
    wr_stb = 1'b0;
    chk(tx_rdy == 1'b0, "R8 ready after write", int'(tx_rdy), 0);
    chk(txd == 1'b1, "R7 not yet started", int'(txd), 1);
    step();
    chk(tx_rdy == 1'b1, "R8 ready after load", int'(tx_rdy), 1);
    check_frame(d);
    chk(txd == 1'b1, "R1 idle after frame", int'(txd), 1);
  endtask

  initial begin
    #1500000;
    chk(1'b0, "watchdog", 0, 1);
    if (!finished) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    set_mode(3, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(txd == 1'b1, "R1 reset line", int'(txd), 1);
    chk(tx_rdy == 1'b1, "R1 reset ready", int'(tx_rdy), 1);
    tx_en = 1'b0; #1;
    chk(tx_rdy == 1'b0, "R9 ready when disabled", int'(tx_rdy), 0);
    tx_en = 1'b1;
    step();

    set_mode(3, 0, 0, 0, 0);  send(8'hA5);
    set_mode(0, 1, 0, 1, 2);  send(8'hFF);
    set_mode(0, 0, 0, 0, 2);  send(8'hE6);
    set_mode(2, 1, 1, 2, 3);  send(8'h3C);
    set_mode(1, 1, 1, 0, 1);  send(8'hC1);

    // R8 back-to-back through the holding register
    set_mode(3, 1, 0, 0, 2);
    wr_data = 8'h96; wr_stb = 1'b1; step();
    wr_stb = 1'b0; step();
    fork
      begin check_frame(8'h96); check_frame(8'h5B); end
      begin
        wr_data = 8'h5B; wr_stb = 1'b1; step();
        wr_stb = 1'b0;
        chk(tx_rdy == 1'b0, "R8 queued byte held", int'(tx_rdy), 0);
      end
    join
    chk(txd == 1'b1, "R8 idle after pair", int'(txd), 1);
    chk(tx_rdy == 1'b1, "R8 ready after pair", int'(tx_rdy), 1);

    // R9 disabled transmitter holds the byte, running frame completes
    set_mode(2, 0, 0, 0, 3);
    tx_en = 1'b0;
    wr_data = 8'h4D; wr_stb = 1'b1; step();
    wr_stb = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk(txd == 1'b1, "R9 no start while disabled", int'(txd), 1);
      chk(tx_rdy == 1'b0, "R9 ready low while disabled", int'(tx_rdy), 0);
      step();
    end
    tx_en = 1'b1; step();
    fork
      check_frame(8'h4D);
      begin step(); tx_en = 1'b0; end
    join
    chk(txd == 1'b1, "R9 idle after frame", int'(txd), 1);
    tx_en = 1'b1; step();

    // R10 break at idle and across a frame
    brk = 1'b1; step();
    for (int i = 0; i < 6; i++) begin
      chk(txd == 1'b0, "R10 idle break low", int'(txd), 0); step();
    end
    set_mode(3, 1, 1, 0, 3);
    wr_data = 8'hFF; wr_stb = 1'b1; step();
    wr_stb = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk(txd == 1'b0, "R10 break over frame", int'(txd), 0); step();
    end
    brk = 1'b0; step();
    chk(txd == 1'b1, "R10 release line", int'(txd), 1);
    chk(tx_rdy == 1'b1, "R10 frame advanced under break", int'(tx_rdy), 1);
    send(8'h81);

    for (int k = 0; k < 30; k++) begin
      int r = ($urandom % 6 == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
      set_mode(int'($urandom % 4), int'($urandom % 2), int'($urandom % 2), r,
               int'($urandom % 4));
      send(8'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule